// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracker

This block is the command front end on the device side of a two-bank synchronous DRAM. Each rising clock edge it samples chip select, the row strobe, the column strobe, write enable, clock enable and a 12-bit address bus. The strobes are decoded into a command, and the address bits are split into row, column, bank and precharge-control fields. The fields are split differently for each command.

The block keeps an open/closed flag and a latched row for each bank. It reports the decoded command and its fields one cycle after the sampling edge. It raises a one-cycle protocol-error pulse when a command does not fit the bank state, and that command has no other effect. A small state machine counts the burst of each accepted read or write. When auto-precharge was requested, the machine closes the bank at the end of the burst.

The state machine has two states. `S_IDLE` is the state with no burst in flight. `S_BURST` is the state with a burst counting down. Its transitions are:
- idle→burst, on an accepted read or write.
- burst→burst, while the counter is above zero or clock enable is low.
- burst→idle, when the counter has reached zero on an enabled edge. This transition fires the auto-precharge close if one is pending.

Top module: `sdram_cmd_front`

## Requirements
- R1: While reset is active, and after it is released, all banks read closed. `cmd_o` is NOP (0), and `proto_err_o` and `burst_active_o` are low.
- R2: With chip select low and clock enable high, {ras_n,cas_n,we_n} is decoded as follows. 011 is ACT (1), 101 is RD (2), 100 is WR (3), 010 is PRE (4), 001 is REF (5), 000 is MRS (6), and 111 or 110 is NOP (0). The decoded value appears on `cmd_o` in the cycle after the sampling edge.
- R3: An ACT to a closed bank opens the bank selected by addr[11] (0 selects bank 0, 1 selects bank 1). It latches addr[10:0] as that bank's row, and it shows the bank on `bank_o` and the row on `row_o`.
- R4: An accepted RD or WR behaves as follows:
  - `bank_o` shows addr[11].
  - `col_o` shows addr[7:0].
  - `auto_pre_o` shows addr[10].
  - `row_o` shows the row latched for that bank.
- R5: A PRE with addr[10]=1 closes both banks whatever addr[11] is. A PRE with addr[10]=0 closes only the bank selected by addr[11]. In both cases `bank_o` shows addr[11].
- R6: Three cases are protocol errors: an RD or WR to a closed bank, an RD or WR while a burst is active, and an ACT to an open bank. Each gives `proto_err_o` high for one cycle with `cmd_o`=NOP, and it leaves the bank flags, the rows, the fields and the burst unchanged.
- R7: After an accepted RD or WR, `burst_active_o` is high for exactly BURST_LEN enabled cycles.
- R8: With auto-precharge set, the bank closes on the enabled edge BURST_LEN edges after the command edge. This is the edge at which `burst_active_o` falls.
- R9: While cs_n is high, no command is taken and `cmd_o` is NOP. A burst already running keeps counting.
- R10: While cke is low, no command is sampled and bank flags, rows, fields and the burst count are frozen. In the following cycle `cmd_o` is NOP and `proto_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Address bus; bit 11 bank, bit 10 precharge control |
| cmd_o | output | 3 | Decoded command code |
| bank_o | output | 1 | Bank of the last accepted bank command |
| row_o | output | 11 | Row of the last activate, read or write |
| col_o | output | 8 | Column of the last read or write |
| auto_pre_o | output | 1 | Auto-precharge flag of the last read or write |
| proto_err_o | output | 1 | One-cycle protocol-error pulse |
| bank_open_o | output | 2 | Open flag per bank |
| burst_active_o | output | 1 | A burst is counting |

## Verification
The hardest situations to reach from the ports are those where several events meet on one edge:
- an auto-precharge close on the same edge as an ACT to the same bank;
- a new read in the last cycle of a burst;
- a burst frozen partway through by clock enable.

Directed phases open a bank and issue a read with auto-precharge. They then place an ACT exactly BURST_LEN edges later, and they drop cke in the middle of a burst. After that, an LFSR-driven phase mixes every strobe pattern with chip select and clock enable toggling. A behavioural model tracks remaining burst cycles as an integer and is compared on every clock.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6
    } sdcf_cmd_e;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_BURST = 1'b1
    } sdcf_burst_e;

endpackage

// File: rtl/sdcf_decode.sv
module sdcf_decode
    import sdcf_pkg::*;
(
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    output sdcf_cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcf_bank.sv
module sdcf_bank #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             open_set,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (cke) begin
            if (open_set) begin
                open_o <= 1'b1;
                row_o  <= row_in;
            end else if (close_req) begin
                open_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdcf_burst.sv
module sdcf_burst
    import sdcf_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic start,
    input  logic ap_in,
    input  logic bank_in,
    output logic busy,
    output logic close_fire,
    output logic close_bank
);

    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    sdcf_burst_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic ap_q, ap_d;
    logic bank_q, bank_d;
    logic last;

    assign last = (state_q == S_BURST) && (cnt_q == '0) && cke;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ap_d    = ap_q;
        bank_d  = bank_q;
        unique case (state_q)
            S_IDLE: begin
                if (cke && start) begin
                    state_d = S_BURST;
                    cnt_d   = CNT_W'(BURST_LEN - 1);
                    ap_d    = ap_in;
                    bank_d  = bank_in;
                end
            end
            S_BURST: begin
                if (cke) begin
                    if (cnt_q == '0) begin
                        state_d = S_IDLE;
                        ap_d    = 1'b0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            ap_q    <= 1'b0;
            bank_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ap_q    <= ap_d;
            bank_q  <= bank_d;
        end
    end

    assign busy       = (state_q == S_BURST);
    assign close_fire = last && ap_q;
    assign close_bank = bank_q;

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdcf_pkg::*;
#(
    parameter int ROW_W     = 11,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [ROW_W:0]   addr,
    output logic [2:0]       cmd_o,
    output logic             bank_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             auto_pre_o,
    output logic             proto_err_o,
    output logic [1:0]       bank_open_o,
    output logic             burst_active_o
);

    localparam int NUM_BANKS = 2;
    localparam int BANK_BIT  = ROW_W;
    localparam int CTRL_BIT  = ROW_W - 1;

    sdcf_cmd_e  cmd_raw;
    logic       bsel;
    logic       sel_open;
    logic       is_rw;
    logic       err;
    logic       act_ok;
    logic       rw_ok;
    logic       pre_hit;
    logic       burst_busy;
    logic       close_fire;
    logic       close_bank;
    logic [NUM_BANKS-1:0] open_v;
    logic [ROW_W-1:0]     row_v [NUM_BANKS];

    sdcf_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd_raw)
    );

    assign bsel     = addr[BANK_BIT];
    assign sel_open = open_v[bsel];
    assign is_rw    = (cmd_raw == CMD_RD) || (cmd_raw == CMD_WR);
    assign err      = cke && ((is_rw && (!sel_open || burst_busy)) ||
                              ((cmd_raw == CMD_ACT) && sel_open));
    assign act_ok   = cke && (cmd_raw == CMD_ACT) && !sel_open;
    assign rw_ok    = cke && is_rw && sel_open && !burst_busy;
    assign pre_hit  = cke && (cmd_raw == CMD_PRE);

    sdcf_burst #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .start      (rw_ok),
        .ap_in      (addr[CTRL_BIT]),
        .bank_in    (bsel),
        .busy       (burst_busy),
        .close_fire (close_fire),
        .close_bank (close_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic set_b;
        logic clr_b;
        assign set_b = act_ok && (bsel == 1'(b));
        assign clr_b = (pre_hit && (addr[CTRL_BIT] || (bsel == 1'(b)))) ||
                       (close_fire && (close_bank == 1'(b)));
        sdcf_bank #(.ROW_W(ROW_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cke       (cke),
            .open_set  (set_b),
            .close_req (clr_b),
            .row_in    (addr[ROW_W-1:0]),
            .open_o    (open_v[b]),
            .row_o     (row_v[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o       <= CMD_NOP;
            proto_err_o <= 1'b0;
            bank_o      <= 1'b0;
            row_o       <= '0;
            col_o       <= '0;
            auto_pre_o  <= 1'b0;
        end else if (!cke) begin
            cmd_o       <= CMD_NOP;
            proto_err_o <= 1'b0;
        end else begin
            proto_err_o <= err;
            cmd_o       <= err ? CMD_NOP : cmd_raw;
            if (act_ok) begin
                bank_o <= bsel;
                row_o  <= addr[ROW_W-1:0];
            end
            if (rw_ok) begin
                bank_o     <= bsel;
                row_o      <= row_v[bsel];
                col_o      <= addr[COL_W-1:0];
                auto_pre_o <= addr[CTRL_BIT];
            end
            if (pre_hit) begin
                bank_o <= bsel;
            end
        end
    end

    assign bank_open_o    = open_v;
    assign burst_active_o = burst_busy;

endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       cs_n,
    input logic [2:0] cmd_o,
    input logic       bank_o,
    input logic       proto_err_o,
    input logic [1:0] bank_open_o,
    input logic       burst_active_o
);

    assert_err_is_nop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> (cmd_o == 3'd0));

    assert_open0_by_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_open_o[0]) |-> ((cmd_o == 3'd1) && (bank_o == 1'b0)));

    assert_open1_by_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_open_o[1]) |-> ((cmd_o == 3'd1) && (bank_o == 1'b1)));

    assert_rw_starts_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == 3'd2) || (cmd_o == 3'd3)) |-> burst_active_o);

    assert_cke_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ((cmd_o == 3'd0) && !proto_err_o && $stable(bank_open_o) &&
                  $stable(burst_active_o)));

    assert_deselect_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cke) |=> ((cmd_o == 3'd0) && !proto_err_o));

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> ((bank_open_o == 2'b00) && !burst_active_o && (cmd_o == 3'd0)));

endmodule

bind sdram_cmd_front sdram_cmd_front_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cke            (cke),
    .cs_n           (cs_n),
    .cmd_o          (cmd_o),
    .bank_o         (bank_o),
    .proto_err_o    (proto_err_o),
    .bank_open_o    (bank_open_o),
    .burst_active_o (burst_active_o)
);

// File: tb/sdram_cmd_front_tb_top.sv
module sdram_cmd_front_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BL = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;

    logic [2:0]  cmd_o;
    logic        bank_o;
    logic [10:0] row_o;
    logic [7:0]  col_o;
    logic        auto_pre_o;
    logic        proto_err_o;
    logic [1:0]  bank_open_o;
    logic        burst_active_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_front #(.ROW_W(11), .COL_W(8), .BURST_LEN(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .cmd_o(cmd_o),
        .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .auto_pre_o(auto_pre_o), .proto_err_o(proto_err_o),
        .bank_open_o(bank_open_o), .burst_active_o(burst_active_o)
    );

    // behavioural reference model
    int        m_cmd, m_bank, m_row, m_col, m_ap, m_err;
    bit [1:0]  m_open;
    int        m_rows [2];
    int        m_left;
    int        m_bap, m_bbank;

    always @(posedge clk) begin
        int c, b, was_busy;
        bit [1:0] old_open;
        if (!rst_n) begin
            m_cmd = 0; m_bank = 0; m_row = 0; m_col = 0; m_ap = 0; m_err = 0;
            m_open = 2'b00; m_rows[0] = 0; m_rows[1] = 0;
            m_left = 0; m_bap = 0; m_bbank = 0;
        end else if (!cke) begin
            m_cmd = 0; m_err = 0;
        end else begin
            old_open = m_open;
            was_busy = (m_left > 0);
            b = addr[11];
            c = 0;
            if (!cs_n) begin
                case ({ras_n, cas_n, we_n})
                    3'b011: c = 1;
                    3'b101: c = 2;
                    3'b100: c = 3;
                    3'b010: c = 4;
                    3'b001: c = 5;
                    3'b000: c = 6;
                    default: c = 0;
                endcase
            end
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0 && m_bap != 0) m_open[m_bbank] = 1'b0;
            end
            m_err = 0;
            if ((c == 2 || c == 3) && (!old_open[b] || was_busy)) m_err = 1;
            if (c == 1 && old_open[b]) m_err = 1;
            m_cmd = m_err ? 0 : c;
            if (!m_err) begin
                if (c == 1) begin
                    m_open[b] = 1'b1; m_rows[b] = addr[10:0];
                    m_bank = b; m_row = addr[10:0];
                end else if (c == 2 || c == 3) begin
                    m_bank = b; m_row = m_rows[b]; m_col = addr[7:0];
                    m_ap = addr[10]; m_left = BL; m_bap = addr[10]; m_bbank = b;
                end else if (c == 4) begin
                    m_bank = b;
                    if (addr[10]) m_open = 2'b00;
                    else m_open[b] = 1'b0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(cmd_o == 3'(m_cmd), "cmd_o (R2)", cmd_o, m_cmd);
            chk(proto_err_o == 1'(m_err), "proto_err_o (R6)", proto_err_o, m_err);
            chk(bank_open_o == m_open, "bank_open_o (R3/R5/R8)", bank_open_o, m_open);
            chk(burst_active_o == (m_left > 0), "burst_active_o (R7)", burst_active_o, m_left > 0);
            chk(bank_o == 1'(m_bank), "bank_o (R4)", bank_o, m_bank);
            chk(row_o == 11'(m_row), "row_o (R3)", row_o, m_row);
            chk(col_o == 8'(m_col), "col_o (R4)", col_o, m_col);
            chk(auto_pre_o == 1'(m_ap), "auto_pre_o (R4)", auto_pre_o, m_ap);
        end
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic issue(input bit cs, input bit r, input bit c, input bit w,
                         input logic [11:0] a, input bit en);
        @(negedge clk);
        cs_n = cs; ras_n = r; cas_n = c; we_n = w; addr = a; cke = en;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(1'b0, 1'b1, 1'b1, 1'b1, 12'h000, 1'b1);
    endtask

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        tag = "R1";
        repeat (3) @(negedge clk);
        checks++;
        if (!(bank_open_o == 2'b00 && cmd_o == 3'd0 && !proto_err_o && !burst_active_o)) begin
            errors++;
            $display("FAIL R1 reset state actual=%0h expected=0", {bank_open_o, cmd_o, proto_err_o, burst_active_o});
        end
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        tag = "R6";  issue(0, 1, 0, 1, 12'h012, 1);           // read to closed bank
        tag = "R3";  issue(0, 0, 1, 1, 12'h5A5, 1);           // act bank 0
        tag = "R6";  issue(0, 0, 1, 1, 12'h123, 1);           // act open bank
        tag = "R4";  issue(0, 1, 0, 1, 12'h033, 1);           // read bank 0 no ap
        tag = "R6";  issue(0, 1, 0, 0, 12'h044, 1);           // write during burst
        tag = "R7";  idle(BL + 1);
        tag = "R3";  issue(0, 0, 1, 1, 12'hC3C, 1);           // act bank 1 row 43C
        tag = "R8";  issue(0, 1, 0, 0, 12'hC77, 1);           // write bank 1 with ap
        idle(BL - 1);
        issue(0, 0, 1, 1, 12'h801, 1);                        // act bank 1 on close edge
        idle(2);
        issue(0, 0, 1, 1, 12'h802, 1);                        // act bank 1 again
        tag = "R5";  issue(0, 0, 1, 0, 12'h000, 1);           // pre bank 0 only
        issue(0, 0, 1, 1, 12'h111, 1);
        issue(0, 0, 1, 0, 12'h400, 1);                        // pre all
        idle(1);
        tag = "R9";  issue(0, 0, 1, 1, 12'h222, 1);
        issue(0, 1, 0, 1, 12'h405, 1);                        // read with ap
        issue(1, 0, 1, 1, 12'h333, 1);                        // deselected act
        issue(1, 0, 1, 0, 12'h400, 1);                        // deselected pre-all
        idle(BL);
        tag = "R10"; issue(0, 0, 1, 1, 12'h666, 1);
        issue(0, 1, 0, 1, 12'h409, 1);
        issue(0, 0, 1, 0, 12'h400, 0);                        // pre-all with cke low
        issue(0, 0, 1, 1, 12'h800, 0);
        issue(0, 0, 1, 1, 12'h800, 0);
        idle(BL + 2);
        tag = "R2";  issue(0, 0, 0, 1, 12'h000, 1);           // refresh
        issue(0, 0, 0, 0, 12'h030, 1);                        // mode set
        issue(0, 1, 1, 0, 12'h000, 1);                        // 110 -> NOP
        issue(0, 0, 1, 0, 12'h400, 1);
        idle(1);

        tag = "R2 random";
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(lfsr[0] & lfsr[7], lfsr[1], lfsr[2], lfsr[3],
                  {lfsr[4], lfsr[5], lfsr[15:6]}, !(lfsr[8] & lfsr[9] & lfsr[11]));
        end
        idle(BL + 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule